// File: doc/BRIEF.md
# Synchronous Clock Stop Gating Controller

This block sits between a set of raw generated clocks and their output pins. It gates them under active-low stop requests without ever producing a shortened pulse. Three differential CPU clock pairs form one group. Seven regular PCI clocks and three free-running PCI clocks form a second group. Two 48 MHz clocks form a third group, which has enables but no stop input.

The whole block runs on one fast sampling clock. Each raw source clock arrives as a level input and is registered once. A falling edge of a source is seen when its registered level goes from 1 to 0.

A stop request becomes effective only on a falling edge of the clock it controls, and so does a release. Per-output enable and free-run bits are also taken on that edge. Stopped CPU pairs either park (true high, complement low) or float to high impedance, as a mode bit selects. Stopped PCI clocks hold low.

Top module: `clkgate_ctrl`

## Requirements
- R1: `cpu_stop_n` passes through a two-stage synchronizer. A stoppable CPU pair halts only on the second CPU-source falling edge that sees the synchronized request. A request seen by fewer falling edges halts nothing.
- R2: With `cpu_hiz_mode` = 0, a halted pair drives `cpu_t` = 1, `cpu_c` = 0 and `cpu_oe` = 1. Whenever `cpu_oe` is 1, `cpu_t` differs from `cpu_c`.
- R3: A pair whose `cpu_free` bit is 1 keeps running during a CPU stop. Bit i of `cpu_free` belongs to pair i.
- R4: With `cpu_hiz_mode` = 1, a halted pair drives `cpu_oe` = 0 and `cpu_t` = `cpu_c` = 0. Pairs that are not halted keep running.
- R5: After the synchronized release, halted pairs restart on the next CPU-source falling edge. Their first high phase is a full source high phase.
- R6: The PCI stop is in effect when the synchronized `pci_stop_n` AND `pci_stop_reg` is 0. Stoppable PCI clocks then hold low from the first PCI-source falling edge that sees the stop.
- R7: The seven regular PCI clocks always obey the PCI stop. Free PCI clock j obeys it only when `pcif_stoppable[j]` = 1.
- R8: After the PCI stop ends, stopped PCI clocks restart on the next PCI-source falling edge, which is within two PCI periods.
- R9: An enable bit of 0 forces its PCI, free PCI or 48 MHz output low. A `cpu_en` bit of 0 parks its pair with `cpu_t` = 1, `cpu_c` = 0 and `cpu_oe` = 1. Enables take effect at the falling edge of the output's own source.
- R10: A gated PCI or 48 MHz output rises only in the cycle its registered source rises, and falls only in the cycle its registered source falls.
- R11: During reset every output is disabled: `cpu_t` = 1, `cpu_c` = 0, `cpu_oe` = 1, and all PCI and 48 MHz outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_src | input | 1 | Raw CPU clock level |
| pci_src | input | 1 | Raw PCI clock level |
| m48_src | input | 1 | Raw 48 MHz clock level |
| cpu_stop_n | input | 1 | Asynchronous CPU stop request, active low |
| pci_stop_n | input | 1 | Asynchronous PCI stop request, active low |
| pci_stop_reg | input | 1 | Register bit ANDed with the synchronized PCI stop pin |
| cpu_hiz_mode | input | 1 | 1: halted pairs float; 0: halted pairs park |
| cpu_free | input | 3 | Per-pair free-run bit (1 = ignores CPU stop) |
| cpu_en | input | 3 | Per-pair enable (0 = parked) |
| pcif_stoppable | input | 3 | Per free PCI clock: 1 = obeys PCI stop |
| pci_en | input | 7 | Regular PCI enables |
| pcif_en | input | 3 | Free PCI enables |
| m48_en | input | 2 | 48 MHz enables |
| cpu_t | output | 3 | CPU true outputs |
| cpu_c | output | 3 | CPU complement outputs |
| cpu_oe | output | 3 | CPU pair drive enables (0 = high impedance) |
| pci_o | output | 7 | Regular PCI outputs |
| pcif_o | output | 3 | Free PCI outputs |
| m48_o | output | 2 | 48 MHz outputs |

## Verification
The assertions check four properties on every cycle:
- driven CPU pairs are never equal;
- floating pairs are quiet and appear only in float mode;
- PCI outputs never rise or fall except together with their registered source;
- 48 MHz outputs never rise except together with their registered source.

Several behaviours depend on sequences and can only be shown by the bench scenarios against its reference model:
- the count of two falling edges before a CPU halt;
- the one-cycle stop pulse that must halt nothing;
- restart latency after a release;
- the per-bit free-run and stoppable masks;
- the AND of the PCI stop pin and the register bit.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;

  typedef enum logic [1:0] {PAIR_RUN, PAIR_PARK, PAIR_FLOAT} pair_drive_e;

  // Falling edges already counted under an active request, saturating.
  function automatic int next_seen(int seen, bit req, int edges);
    if (!req) return 0;
    return (seen >= edges - 1) ? edges - 1 : seen + 1;
  endfunction

  // True when the current falling edge completes the required count.
  function automatic bit halt_on_edge(int seen, bit req, int edges);
    return req && (seen >= edges - 1);
  endfunction

  function automatic pair_drive_e pair_drive(bit stopped, bit disabled, bit float_mode);
    if (stopped) return float_mode ? PAIR_FLOAT : PAIR_PARK;
    if (disabled) return PAIR_PARK;
    return PAIR_RUN;
  endfunction

endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) pipe[s] <= '1;
    end else begin
      pipe[0] <= d;
      for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/clkgate_lane.sv
module clkgate_lane #(
  parameter int N          = 3,
  parameter int STOP_EDGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src,
  input  logic         stop_req,
  input  logic [N-1:0] stoppable,
  input  logic [N-1:0] enable,
  output logic         lvl,
  output logic         fall,
  output logic [N-1:0] stop_q,
  output logic [N-1:0] dis_q
);
  import clkgate_pkg::*;

  localparam int CW = (STOP_EDGES > 1) ? $clog2(STOP_EDGES) : 1;

  logic          src_d1;
  logic [CW-1:0] seen_q;
  logic          halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl    <= 1'b0;
      src_d1 <= 1'b0;
    end else begin
      lvl    <= src;
      src_d1 <= lvl;
    end
  end

  assign fall = src_d1 & ~lvl;
  assign halt = halt_on_edge(int'(seen_q), stop_req, STOP_EDGES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else if (fall) seen_q <= CW'(next_seen(int'(seen_q), stop_req, STOP_EDGES));
  end

  for (genvar i = 0; i < N; i++) begin : g_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stop_q[i] <= 1'b0;
        dis_q[i]  <= 1'b1;
      end else if (fall) begin
        stop_q[i] <= stoppable[i] & halt;
        dis_q[i]  <= ~enable[i];
      end
    end
  end
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl #(
  parameter int N_CPU      = 3,
  parameter int N_PCI      = 7,
  parameter int N_PCIF     = 3,
  parameter int N_M48      = 2,
  parameter int CPU_EDGES  = 2,
  parameter int PCI_EDGES  = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_src,
  input  logic              pci_src,
  input  logic              m48_src,
  input  logic              cpu_stop_n,
  input  logic              pci_stop_n,
  input  logic              pci_stop_reg,
  input  logic              cpu_hiz_mode,
  input  logic [N_CPU-1:0]  cpu_free,
  input  logic [N_CPU-1:0]  cpu_en,
  input  logic [N_PCIF-1:0] pcif_stoppable,
  input  logic [N_PCI-1:0]  pci_en,
  input  logic [N_PCIF-1:0] pcif_en,
  input  logic [N_M48-1:0]  m48_en,
  output logic [N_CPU-1:0]  cpu_t,
  output logic [N_CPU-1:0]  cpu_c,
  output logic [N_CPU-1:0]  cpu_oe,
  output logic [N_PCI-1:0]  pci_o,
  output logic [N_PCIF-1:0] pcif_o,
  output logic [N_M48-1:0]  m48_o
);
  import clkgate_pkg::*;

  localparam int N_PALL = N_PCI + N_PCIF;

  // Synchronized stop pins: bit 0 CPU, bit 1 PCI.
  logic [1:0] pins_sync;
  logic       cpu_req, pci_req;

  clkgate_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({pci_stop_n, cpu_stop_n}),
    .q(pins_sync)
  );

  assign cpu_req = ~pins_sync[0];
  assign pci_req = ~(pins_sync[1] & pci_stop_reg);

  // CPU group
  logic             cpu_lvl, cpu_fall;
  logic [N_CPU-1:0] cpu_stop_q, cpu_dis_q;

  clkgate_lane #(.N(N_CPU), .STOP_EDGES(CPU_EDGES)) u_cpu_lane (
    .clk(clk), .rst_n(rst_n), .src(cpu_src), .stop_req(cpu_req),
    .stoppable(~cpu_free), .enable(cpu_en),
    .lvl(cpu_lvl), .fall(cpu_fall), .stop_q(cpu_stop_q), .dis_q(cpu_dis_q)
  );

  for (genvar i = 0; i < N_CPU; i++) begin : g_pair
    pair_drive_e drv;
    assign drv = pair_drive(cpu_stop_q[i], cpu_dis_q[i], cpu_hiz_mode);
    always_comb begin
      unique case (drv)
        PAIR_RUN:   begin cpu_t[i] = cpu_lvl; cpu_c[i] = ~cpu_lvl; cpu_oe[i] = 1'b1; end
        PAIR_PARK:  begin cpu_t[i] = 1'b1;    cpu_c[i] = 1'b0;     cpu_oe[i] = 1'b1; end
        default:    begin cpu_t[i] = 1'b0;    cpu_c[i] = 1'b0;     cpu_oe[i] = 1'b0; end
      endcase
    end
  end

  // PCI group: regular clocks in the low bits, free clocks above.
  logic              pci_lvl, pci_fall;
  logic [N_PALL-1:0] pci_stop_q, pci_dis_q, pci_gated;

  clkgate_lane #(.N(N_PALL), .STOP_EDGES(PCI_EDGES)) u_pci_lane (
    .clk(clk), .rst_n(rst_n), .src(pci_src), .stop_req(pci_req),
    .stoppable({pcif_stoppable, {N_PCI{1'b1}}}), .enable({pcif_en, pci_en}),
    .lvl(pci_lvl), .fall(pci_fall), .stop_q(pci_stop_q), .dis_q(pci_dis_q)
  );

  assign pci_gated = {N_PALL{pci_lvl}} & ~pci_stop_q & ~pci_dis_q;
  assign pci_o     = pci_gated[N_PCI-1:0];
  assign pcif_o    = pci_gated[N_PALL-1:N_PCI];

  // 48 MHz group: enables only.
  logic             m48_lvl, m48_fall;
  logic [N_M48-1:0] m48_stop_q, m48_dis_q;

  clkgate_lane #(.N(N_M48), .STOP_EDGES(1)) u_m48_lane (
    .clk(clk), .rst_n(rst_n), .src(m48_src), .stop_req(1'b0),
    .stoppable({N_M48{1'b0}}), .enable(m48_en),
    .lvl(m48_lvl), .fall(m48_fall), .stop_q(m48_stop_q), .dis_q(m48_dis_q)
  );

  assign m48_o = {N_M48{m48_lvl}} & ~m48_stop_q & ~m48_dis_q;
endmodule

// File: rtl/clkgate_ctrl_chk.sv
module clkgate_ctrl_chk #(
  parameter int N_CPU  = 3,
  parameter int N_PCI  = 7,
  parameter int N_PCIF = 3,
  parameter int N_M48  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_hiz_mode,
  input logic [N_CPU-1:0]  cpu_t,
  input logic [N_CPU-1:0]  cpu_c,
  input logic [N_CPU-1:0]  cpu_oe,
  input logic [N_PCI-1:0]  pci_o,
  input logic [N_PCIF-1:0] pcif_o,
  input logic              pci_lvl,
  input logic [N_M48-1:0]  m48_o,
  input logic              m48_lvl
);
  logic [N_PCI+N_PCIF-1:0] pci_all;
  assign pci_all = {pcif_o, pci_o};

  assert_pair_distinct_R2: assert property (@(posedge clk) disable iff (!rst_n)
    &((cpu_t ^ cpu_c) | ~cpu_oe));

  assert_float_only_in_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_oe != {N_CPU{1'b1}}) |-> cpu_hiz_mode);

  assert_float_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(~cpu_oe & (cpu_t | cpu_c))));

  assert_pci_rise_with_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pci_all & ~$past(pci_all))) |-> (pci_lvl && !$past(pci_lvl)));

  assert_pci_fall_with_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(~pci_all & $past(pci_all))) |-> (!pci_lvl && $past(pci_lvl)));

  assert_m48_rise_with_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(m48_o & ~$past(m48_o))) |-> (m48_lvl && !$past(m48_lvl)));
endmodule

bind clkgate_ctrl clkgate_ctrl_chk #(
  .N_CPU(N_CPU), .N_PCI(N_PCI), .N_PCIF(N_PCIF), .N_M48(N_M48)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_hiz_mode(cpu_hiz_mode),
  .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_oe(cpu_oe),
  .pci_o(pci_o), .pcif_o(pcif_o), .pci_lvl(pci_lvl),
  .m48_o(m48_o), .m48_lvl(m48_lvl)
);

// File: tb/test_clkgate_ctrl.sv
module test_clkgate_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_src = 0, pci_src = 0, m48_src = 0;
  logic cpu_stop_n = 1, pci_stop_n = 1, pci_stop_reg = 1, cpu_hiz_mode = 0;
  logic [2:0] cpu_free = 0, cpu_en = 3'b111, pcif_stoppable = 0, pcif_en = 3'b111;
  logic [6:0] pci_en = 7'h7F;
  logic [1:0] m48_en = 2'b11;
  logic [2:0] cpu_t, cpu_c, cpu_oe, pcif_o;
  logic [6:0] pci_o;
  logic [1:0] m48_o;

  int checks = 0, fails = 0, k = 0;
  bit done = 0;
  string tag = "R11";

  always #4 clk = ~clk;

  clkgate_ctrl i_clkgate_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_src(cpu_src), .pci_src(pci_src), .m48_src(m48_src),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pci_stop_reg(pci_stop_reg),
    .cpu_hiz_mode(cpu_hiz_mode), .cpu_free(cpu_free), .cpu_en(cpu_en),
    .pcif_stoppable(pcif_stoppable), .pci_en(pci_en), .pcif_en(pcif_en), .m48_en(m48_en),
    .cpu_t(cpu_t), .cpu_c(cpu_c), .cpu_oe(cpu_oe), .pci_o(pci_o), .pcif_o(pcif_o), .m48_o(m48_o)
  );

  // Reference model: index 0 CPU, 1 PCI, 2 48 MHz.
  int sq[3], sd[3], seen[3];
  int y1[2], y2[2];
  bit mstop_cpu[3], mdis_cpu[3], mstop_pci[10], mdis_pci[10], mdis48[2];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int g = 0; g < 3; g++) begin sq[g] = 0; sd[g] = 0; seen[g] = 0; end
      for (int p = 0; p < 2; p++) begin y1[p] = 1; y2[p] = 1; end
      for (int i = 0; i < 3; i++) begin mstop_cpu[i] = 0; mdis_cpu[i] = 1; end
      for (int i = 0; i < 10; i++) begin mstop_pci[i] = 0; mdis_pci[i] = 1; end
      for (int i = 0; i < 2; i++) mdis48[i] = 1;
    end else begin
      bit reqc, reqp;
      reqc = (y2[0] == 0);
      reqp = !((y2[1] == 1) && pci_stop_reg);
      if (sd[0] == 1 && sq[0] == 0) begin
        seen[0] = reqc ? ((seen[0] < 50) ? seen[0] + 1 : 50) : 0;
        for (int i = 0; i < 3; i++) begin
          mstop_cpu[i] = (seen[0] >= 2) && !cpu_free[i];
          mdis_cpu[i] = !cpu_en[i];
        end
      end
      if (sd[1] == 1 && sq[1] == 0) begin
        for (int i = 0; i < 10; i++) begin
          bit obey;
          obey = (i < 7) ? 1'b1 : pcif_stoppable[i-7];
          mstop_pci[i] = reqp && obey;
          mdis_pci[i] = (i < 7) ? !pci_en[i] : !pcif_en[i-7];
        end
      end
      if (sd[2] == 1 && sq[2] == 0)
        for (int i = 0; i < 2; i++) mdis48[i] = !m48_en[i];
      sd[0] = sq[0]; sq[0] = cpu_src;
      sd[1] = sq[1]; sq[1] = pci_src;
      sd[2] = sq[2]; sq[2] = m48_src;
      y2[0] = y1[0]; y1[0] = cpu_stop_n;
      y2[1] = y1[1]; y1[1] = pci_stop_n;
    end
  end

  logic [2:0] acc_t_hi, acc_t_lo, acc_pf_hi, acc_pf_lo;
  logic [6:0] acc_p_hi, acc_p_lo;
  logic [1:0] acc_m_hi;

  task automatic compare();
    logic [2:0] et, ec, eo, ef;
    logic [6:0] ep;
    logic [1:0] em;
    for (int i = 0; i < 3; i++) begin
      if (mstop_cpu[i] && cpu_hiz_mode) begin et[i] = 0; ec[i] = 0; eo[i] = 0; end
      else if (mstop_cpu[i] || mdis_cpu[i]) begin et[i] = 1; ec[i] = 0; eo[i] = 1; end
      else begin et[i] = sq[0][0]; ec[i] = !sq[0][0]; eo[i] = 1; end
    end
    for (int i = 0; i < 7; i++) ep[i] = sq[1][0] && !mstop_pci[i] && !mdis_pci[i];
    for (int i = 0; i < 3; i++) ef[i] = sq[1][0] && !mstop_pci[i+7] && !mdis_pci[i+7];
    for (int i = 0; i < 2; i++) em[i] = sq[2][0] && !mdis48[i];
    checks++;
    if ({cpu_t, cpu_c, cpu_oe, pci_o, pcif_o, m48_o} !== {et, ec, eo, ep, ef, em}) begin
      fails++;
      $display("FAIL %s cycle %0d: t/c/oe=%b/%b/%b pci=%b pcif=%b m48=%b, expected %b/%b/%b %b %b %b",
               tag, k, cpu_t, cpu_c, cpu_oe, pci_o, pcif_o, m48_o, et, ec, eo, ep, ef, em);
    end
  endtask

  task automatic run(int n, string t);
    tag = t;
    acc_t_hi = 0; acc_t_lo = 0; acc_p_hi = 0; acc_p_lo = 0;
    acc_pf_hi = 0; acc_pf_lo = 0; acc_m_hi = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare();
      acc_t_hi |= cpu_t; acc_t_lo |= ~cpu_t;
      acc_p_hi |= pci_o; acc_p_lo |= ~pci_o;
      acc_pf_hi |= pcif_o; acc_pf_lo |= ~pcif_o; acc_m_hi |= m48_o;
      k++;
      cpu_src = (k % 4) < 2;
      pci_src = (k % 8) < 4;
      m48_src = (k % 6) < 3;
    end
  endtask

  task automatic expect_eq(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", t, act, exp);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R11 reset state
    repeat (3) @(negedge clk);
    expect_eq("R11 reset outputs", {cpu_t, cpu_c, cpu_oe, pci_o, pcif_o, m48_o},
              {3'b111, 3'b000, 3'b111, 7'h00, 3'b000, 2'b00});
    rst_n = 1'b1;
    run(40, "R10 free running");
    expect_eq("R10 pci toggles", {acc_p_hi, acc_p_lo}, {7'h7F, 7'h7F});

    // R1 short stop pulse must halt nothing
    cpu_stop_n = 0; run(1, "R1 pulse"); cpu_stop_n = 1;
    run(12, "R1 pulse"); run(16, "R1 pulse");
    expect_eq("R1 short pulse no halt", {acc_t_hi, acc_t_lo}, {3'b111, 3'b111});

    // CPU stop, park mode, pair 1 free
    cpu_free = 3'b010; cpu_stop_n = 0;
    run(16, "R1 R2 R3 stop entry"); run(24, "R2 R3 stopped");
    expect_eq("R2 pair0 parked high", {acc_t_lo[0], acc_t_hi[0]}, 2'b01);
    expect_eq("R3 pair1 free running", {acc_t_hi[1], acc_t_lo[1]}, 2'b11);
    cpu_stop_n = 1;
    run(12, "R5 resume"); run(12, "R5 running");
    expect_eq("R5 pair0 resumed", {acc_t_hi[0], acc_t_lo[0]}, 2'b11);

    // CPU stop, float mode, pair 0 free
    cpu_hiz_mode = 1; cpu_free = 3'b001; cpu_stop_n = 0;
    run(16, "R4 float entry"); run(8, "R4 floating");
    expect_eq("R4 oe pattern", cpu_oe, 3'b001);
    cpu_stop_n = 1; run(16, "R5 float release");
    cpu_hiz_mode = 0; cpu_free = 3'b000;

    // PCI stop from pin, free clocks 0 and 2 stoppable
    pcif_stoppable = 3'b101; pci_stop_n = 0;
    run(16, "R6 R7 pin stop"); run(24, "R6 R7 stopped");
    expect_eq("R6 regular pci held low", acc_p_hi, 7'h00);
    expect_eq("R7 free pci mask", acc_pf_hi, 3'b010);
    pci_stop_n = 1;
    run(20, "R8 release"); run(16, "R8 running");
    expect_eq("R8 pci restarted", {acc_p_hi, acc_pf_hi}, {7'h7F, 3'b111});

    // PCI stop from register bit
    pci_stop_reg = 0; run(12, "R6 reg stop"); run(16, "R6 reg stopped");
    expect_eq("R6 reg bit stops pci", {acc_p_hi, acc_pf_hi}, {7'h00, 3'b010});
    pci_stop_reg = 1; run(20, "R8 reg release");

    // Enables
    pci_en = 7'b0101010; pcif_en = 3'b011; m48_en = 2'b10; cpu_en = 3'b110;
    run(20, "R9 enables"); run(24, "R9 enabled");
    expect_eq("R9 pci enables", {acc_p_hi, acc_pf_hi, acc_m_hi}, {7'b0101010, 3'b011, 2'b10});
    expect_eq("R9 cpu pair0 parked", {acc_t_lo[0], acc_t_hi[0]}, 2'b01);
    pci_en = 7'h7F; pcif_en = 3'b111; m48_en = 2'b11; cpu_en = 3'b111;
    run(20, "R10 final");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule